// File: doc/BRIEF.md
# Canonical Signed-Digit Single-Step Adder

This block adds two signed-digit operands of N digits each, where every digit is -1, 0 or +1. Each operand must be in canonical form, meaning no two neighbouring digits are both non-zero. Under that rule the result needs no carry chain. Each result digit is settled by a window of four operand digits: the two digits at its own position and the two digits one position lower. The whole sum therefore forms in one shallow layer of logic, whatever the width.

The result has N+1 digits. An operand strobe (`in_valid`) captures the result into a register. The same strobe captures a flag that reports a malformed operand. When `op_sub` is asserted, the block forms the difference by negating every digit of the second operand before the window logic.

The result is not itself canonical. Re-normalising it, and converting arbitrary numbers into canonical form, is left to the logic around the block.

Top module: `csd_add_top`

## Requirements
- R1: Each digit is a 2-bit code: 2'b00 = 0, 2'b01 = +1, 2'b11 = -1. Digit i occupies bits [2i+1:2i] of its vector, so digit 0 (weight 1) is in bits [1:0].
- R2: Result digit i depends only on operand digits q_i, r_i, q_(i-1) and r_(i-1), with zero digits assumed below position 0 and above position N-1.
  - It is +1 for exactly three windows: (q_i, r_i, q_(i-1), r_(i-1)) = (0, +1, any, 0), (+1, 0, 0, any), (0, 0, +1, +1).
  - It is -1 for the digit-wise negations of those three windows.
  - It is 0 for every other window.
- R3: For canonical operands with op_sub = 0, the N+1-digit result equals Q + R as an integer.
- R4: With op_sub = 1, the second operand's digits are negated (+1 and -1 swap, 0 stays), so the result equals Q - R.
- R5: The result and the error flag are loaded on the rising edge at which in_valid is 1. out_valid is 1 for exactly the cycle after each such edge and 0 otherwise.
- R6: While in_valid is 0, sum_dig and non_canon keep their last loaded values whatever the operand inputs do.
- R7: non_canon is loaded as 1 when either raw operand holds two adjacent non-zero digits or any digit code 2'b10, and is loaded as 0 otherwise. When it is 1, the sum value is undefined.
- R8: While rst_n is low, out_valid, sum_dig and non_canon are all 0.
- R9: The top result digit N is the carry out of digit N-1. For example, when both operands are +1 in digit N-1 only, the result is +1 in digit N and 0 in every other digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Loads a new result at this edge |
| op_sub | input | 1 | 1 = subtract r_dig from q_dig |
| q_dig | input | 2*N | First operand, N digit codes |
| r_dig | input | 2*N | Second operand, N digit codes |
| out_valid | output | 1 | High the cycle after a load |
| sum_dig | output | 2*(N+1) | Registered result, N+1 digit codes |
| non_canon | output | 1 | Registered malformed-operand flag |

## Verification
Negation for subtraction and the canonical-form check act on the same strobe. The check must look at the raw second operand, not the negated copy. The bench provokes this overlap with an illegal 2'b10 code in the subtrahend and with a pair of adjacent -1 digits under op_sub = 1, and requires the flag to rise in both cases. A later clean subtraction must then clear the flag and return the right integer difference. The result decodes to a signed integer, and the bench judges it against the difference it computes itself from the operands it first recoded into canonical form.

// File: rtl/csd_add_pkg.sv
package csd_add_pkg;

    typedef logic [1:0] dcode_t;

    localparam dcode_t D_ZERO = 2'b00;
    localparam dcode_t D_POS  = 2'b01;
    localparam dcode_t D_NEG  = 2'b11;

    // Swap +1 and -1; zero (and the unused code) maps to zero.
    function automatic dcode_t dneg(dcode_t c);
        return {c[0] & ~c[1], c[0]};
    endfunction

    function automatic logic is_nz(dcode_t c);
        return (c == D_POS) || (c == D_NEG);
    endfunction

endpackage

// File: rtl/csd_negate.sv
module csd_negate
    import csd_add_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [2*N-1:0] din,
    input  logic           en,
    output logic [2*N-1:0] dout
);
    for (genvar i = 0; i < N; i++) begin : g_dig
        dcode_t d_in;
        dcode_t d_out;

        assign d_in            = din[2*i +: 2];
        assign d_out           = en ? dneg(d_in) : d_in;
        assign dout[2*i +: 2]  = d_out;

        always_comb begin
            if (en && is_nz(d_in)) begin
                assert_neg_flips_R4: assert (is_nz(d_out) && (d_out != d_in));
            end
        end
    end
endmodule

// File: rtl/csd_canon_check.sv
module csd_canon_check
    import csd_add_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [2*N-1:0] din,
    output logic           bad
);
    localparam int NPAIR = N - 1;

    logic [N-1:0]     illegal;
    logic [NPAIR-1:0] adjacent;

    for (genvar i = 0; i < N; i++) begin : g_ill
        assign illegal[i] = (din[2*i +: 2] == 2'b10);
    end

    for (genvar i = 0; i < NPAIR; i++) begin : g_adj
        assign adjacent[i] = is_nz(din[2*i +: 2]) && is_nz(din[2*(i+1) +: 2]);
    end

    assign bad = (|illegal) || (|adjacent);
endmodule

// File: rtl/csd_window_cell.sv
module csd_window_cell
    import csd_add_pkg::*;
(
    input  dcode_t q_cur,
    input  dcode_t r_cur,
    input  dcode_t q_low,
    input  dcode_t r_low,
    output dcode_t z
);
    logic pos;
    logic neg;

    always_comb begin
        pos = ((q_cur == D_ZERO) && (r_cur == D_POS)  && (r_low == D_ZERO))
           || ((q_cur == D_POS)  && (r_cur == D_ZERO) && (q_low == D_ZERO))
           || ((q_cur == D_ZERO) && (r_cur == D_ZERO) && (q_low == D_POS) && (r_low == D_POS));
        neg = ((q_cur == D_ZERO) && (r_cur == D_NEG)  && (r_low == D_ZERO))
           || ((q_cur == D_NEG)  && (r_cur == D_ZERO) && (q_low == D_ZERO))
           || ((q_cur == D_ZERO) && (r_cur == D_ZERO) && (q_low == D_NEG) && (r_low == D_NEG));
        if (pos)      z = D_POS;
        else if (neg) z = D_NEG;
        else          z = D_ZERO;
        assert_window_exclusive_R2: assert (!(pos && neg));
    end
endmodule

// File: rtl/csd_add_top.sv
module csd_add_top
    import csd_add_pkg::*;
#(
    parameter int N = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               op_sub,
    input  logic [2*N-1:0]     q_dig,
    input  logic [2*N-1:0]     r_dig,
    output logic               out_valid,
    output logic [2*(N+1)-1:0] sum_dig,
    output logic               non_canon
);
    localparam int ND   = N + 1;
    localparam int SW   = 2 * ND;
    localparam int PADW = 2 * (N + 2);

    typedef struct packed {
        logic          vld;
        logic [SW-1:0] sum;
        logic          err;
    } state_t;

    state_t st_d, st_q;

    logic [2*N-1:0]  r_eff;
    logic            q_bad, r_bad;
    logic [PADW-1:0] q_pad, r_pad;
    logic [SW-1:0]   sum_w;

    csd_negate #(.N(N)) u_neg (
        .din (r_dig),
        .en  (op_sub),
        .dout(r_eff)
    );

    csd_canon_check #(.N(N)) u_chk_q (.din(q_dig), .bad(q_bad));
    csd_canon_check #(.N(N)) u_chk_r (.din(r_dig), .bad(r_bad));

    // Zero digit below position 0 and above position N-1.
    assign q_pad = {2'b00, q_dig, 2'b00};
    assign r_pad = {2'b00, r_eff, 2'b00};

    for (genvar i = 0; i < ND; i++) begin : g_cell
        csd_window_cell u_cell (
            .q_cur(q_pad[2*(i+1) +: 2]),
            .r_cur(r_pad[2*(i+1) +: 2]),
            .q_low(q_pad[2*i +: 2]),
            .r_low(r_pad[2*i +: 2]),
            .z    (sum_w[2*i +: 2])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.sum = sum_w;
            st_d.err = q_bad || r_bad;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign sum_dig   = st_q.sum;
    assign non_canon = st_q.err;

    assert_valid_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(sum_dig) && $stable(non_canon)));
    assert_zero_operands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (q_dig == '0) && (r_dig == '0)) |=> ((sum_dig == '0) && !non_canon));
endmodule

// File: tb/sim_csd_add_top.sv
`timescale 1ns/1ps
module sim_csd_add_top;
    localparam int N = 8;
    localparam int W = 2 * (N + 1);
    localparam int NV = 10;
    // {a, b, op_sub, expected}
    localparam int TAB [NV][4] = '{
        '{11, -9, 0, 2},     '{5, 3, 0, 8},      '{127, 127, 0, 254},
        '{-127, -127, 0, -254}, '{100, -37, 1, 137}, '{-64, 64, 1, -128},
        '{0, 0, 1, 0},       '{85, -85, 0, 0},   '{43, 21, 1, 22},
        '{-1, 1, 0, 0}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic           op_sub = 1'b0;
    logic [2*N-1:0] q_dig = '0;
    logic [2*N-1:0] r_dig = '0;
    logic           out_valid;
    logic [W-1:0]   sum_dig;
    logic           non_canon;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    csd_add_top #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
        .q_dig(q_dig), .r_dig(r_dig), .out_valid(out_valid),
        .sum_dig(sum_dig), .non_canon(non_canon)
    );

    function automatic logic [2*N-1:0] to_csd(int v);
        logic [2*N-1:0] c = '0;
        int x = v;
        for (int i = 0; i < N; i++) begin
            if (x % 2 != 0) begin
                int m = ((x % 4) + 4) % 4;
                if (m == 1) begin c[2*i +: 2] = 2'b01; x = x - 1; end
                else        begin c[2*i +: 2] = 2'b11; x = x + 1; end
            end
            x = x / 2;
        end
        return c;
    endfunction

    function automatic int from_csd(logic [W-1:0] s);
        int v = 0;
        for (int i = N; i >= 0; i--) begin
            v = v * 2;
            if (s[2*i +: 2] == 2'b01) v = v + 1;
            else if (s[2*i +: 2] == 2'b11) v = v - 1;
        end
        return v;
    endfunction

    task automatic check_int(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_vec(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(logic [2*N-1:0] q, logic [2*N-1:0] r, logic s);
        @(negedge clk);
        q_dig = q; r_dig = r; op_sub = s; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_pair(int a, int b, int s, int exp, string tag);
        drive(to_csd(a), to_csd(b), s[0]);
        check_int({tag, " R5 out_valid"}, int'(out_valid), 1);
        check_int({tag, " R3/R4 value"}, from_csd(sum_dig), exp);
        check_int({tag, " R7 clean flag"}, int'(non_canon), 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R8: reset state
        repeat (3) @(negedge clk);
        check_int("R8 out_valid", int'(out_valid), 0);
        check_vec("R8 sum", sum_dig, '0);
        check_int("R8 flag", int'(non_canon), 0);
        rst_n = 1'b1;

        // Table walk (R3, R4)
        for (int k = 0; k < NV; k++) begin
            run_pair(TAB[k][0], TAB[k][1], TAB[k][2], TAB[k][3], "table");
        end

        // R1/R2: 11 + (-9), exact digit pattern 0,-1,-1,-1,+1
        drive(16'h0133, 16'h00C3, 1'b0);
        check_vec("R1 R2 digit pattern", sum_dig, 18'h001FC);

        // R9: carry into top digit
        drive(16'h4000, 16'h4000, 1'b0);
        check_vec("R9 positive carry", sum_dig, 18'h10000);
        drive(16'hC000, 16'hC000, 1'b0);
        check_vec("R9 negative carry", sum_dig, 18'h30000);

        // R6 and R5: hold while strobe low
        run_pair(11, -9, 0, 2, "pre-hold");
        @(negedge clk);
        check_int("R5 out_valid drop", int'(out_valid), 0);
        q_dig = 16'h5555; r_dig = 16'hAAAA; op_sub = 1'b1;
        repeat (3) @(negedge clk);
        check_int("R6 sum held", from_csd(sum_dig), 2);
        check_int("R6 flag held low", int'(non_canon), 0);

        // R7: malformed operands
        drive(16'h0005, 16'h0000, 1'b0);
        check_int("R7 adjacent +1 in q", int'(non_canon), 1);
        repeat (2) @(negedge clk);
        check_int("R6 flag held high", int'(non_canon), 1);
        drive(16'h0000, 16'h0080, 1'b1);
        check_int("R7 code 10 in r under subtract", int'(non_canon), 1);
        drive(16'h0000, 16'h3C00, 1'b1);
        check_int("R7 adjacent -1 in r under subtract", int'(non_canon), 1);
        run_pair(37, 90, 1, -53, "R7 flag clears");

        // Random recoded pairs (R3, R4)
        for (int k = 0; k < 300; k++) begin
            int a = int'($urandom_range(254)) - 127;
            int b = int'($urandom_range(254)) - 127;
            int s = int'($urandom_range(1));
            run_pair(a, b, s, (s != 0) ? a - b : a + b, "random");
        end

        finish_run();
    end
endmodule